// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This controller paces the retries of an atomic compare-and-swap that keeps losing to competing requesters. A start pulse marks the beginning of a new atomic operation and loads a backoff count of one. Each failure that the requester reports turns the current count into one stall request sent to a downstream pause unit. The requested length is the count times 128 cycles. The count then doubles, so that later retries wait longer and longer.

Doubling is gated by a cap. While the count is at or below 4096 a failure shifts it left by one place. Once the count has grown past 4096 (that is, reached 8192) it stays there. The largest stall request is therefore 8192 × 128 = 1,048,576 cycles. Each failure is issued as one request for the whole amount, never as a series of fixed-size slices.

The request is held with a valid/acknowledge handshake. A success pulse returns the controller to idle. A new start pulse restarts the sequence at any time.

Top module: `backoff_retry`

## Requirements
- R1: After reset, `stallValid` is 0.
- R2: After `opStart`, the first accepted failure requests a stall of exactly 128 cycles (count 1).
- R3: Each accepted failure doubles the count, so successive requests of one operation are 128, 256, 512, ... cycles.
- R4: Doubling happens only while the count is at most 4096. The count saturates at 8192, and every later request is 1,048,576 cycles.
- R5: An accepted failure raises `stallValid` one cycle after the failure pulse. `stallLen` equals count × 128: a power of two with its low 7 bits zero.
- R6: While `stallValid` is 1 and `stallAck` is 0, `stallValid` and `stallLen` hold. In the cycle after `stallAck` is sampled high, `stallValid` is 0.
- R7: A failure pulse while a request is outstanding is ignored. The length of the pending request does not change, and the next request after the acknowledge is only one doubling further on.
- R8: `opDone` returns the controller to idle and withdraws any outstanding request. A failure while idle raises no request.
- R9: `opStart` during an operation, including while a request is outstanding, withdraws the request and reloads the count to 1.
- R10: Priority in one cycle is `opStart`, then `opDone`, then `opFail`. A failure that coincides with a start or a success raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opStart | input | 1 | Pulse: a new atomic operation begins |
| opFail | input | 1 | Pulse: the current attempt failed |
| opDone | input | 1 | Pulse: the operation succeeded |
| stallAck | input | 1 | Pause unit accepts the outstanding request |
| stallValid | output | 1 | A stall request is outstanding |
| stallLen | output | 21 | Requested stall length in cycles |

## Verification
The main function is tried with a long, acknowledged run of failures. That run tells correct doubling apart from off-by-one shifts, and correct saturation apart from a wrong compare at the 4096 boundary. Failures are also sent while a request is outstanding and not acknowledged; this separates an ignored failure from one that corrupts the pending length or doubles the count twice. Failures are also sent while idle, and in the same cycle as start or success pulses. These show the priority order and that stray failures raise nothing. Starts and successes that arrive mid-request show that the request is withdrawn and that the count reloads to one.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_STALL  = 2'd2
  } boState_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic loadOne;  // reload count to 1
    logic advance;  // capture stall length from count, then double (gated)
  } boStrobe_t;

endpackage

// File: rtl/backoff_datapath.sv
module backoff_datapath
  import backoff_pkg::*;
#(
  parameter int CAP_LIMIT   = 4096,
  parameter int PAUSE_SHIFT = 7,
  localparam int CNT_W = $clog2(CAP_LIMIT) + 2,
  localparam int LEN_W = CNT_W + PAUSE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  boStrobe_t        strobe,
  output logic [LEN_W-1:0] stallLen
);

  localparam logic [CNT_W-1:0] CAP_VAL = CNT_W'(CAP_LIMIT);
  localparam logic [CNT_W-1:0] ONE_VAL = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic             mayDouble;

  assign mayDouble = (cnt <= CAP_VAL);

  always_comb begin
    cntNext = cnt;
    if (strobe.loadOne)
      cntNext = ONE_VAL;
    else if (strobe.advance && mayDouble)
      cntNext = {cnt[CNT_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= ONE_VAL;
    else
      cnt <= cntNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stallLen <= '0;
    else if (strobe.advance)
      stallLen <= {cnt, {PAUSE_SHIFT{1'b0}}};
  end

  // R3: the count is always a single set bit
  assert_cnt_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cnt) == 1);

  // R4: the count never grows beyond twice the cap
  assert_cnt_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= {CAP_VAL[CNT_W-2:0], 1'b0});

  // R4: a saturated count stays put when advanced
  assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && !strobe.loadOne && cnt > CAP_VAL) |=> $stable(cnt));

endmodule

// File: rtl/backoff_ctrl.sv
module backoff_ctrl
  import backoff_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      opStart,
  input  logic      opFail,
  input  logic      opDone,
  input  logic      stallAck,
  output boStrobe_t strobe,
  output logic      stallValid
);

  boState_e state;
  boState_e stateNext;

  always_comb begin
    stateNext      = state;
    strobe.loadOne = 1'b0;
    strobe.advance = 1'b0;
    if (opStart) begin
      stateNext      = ST_ACTIVE;
      strobe.loadOne = 1'b1;
    end else if (opDone) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_ACTIVE: if (opFail) begin
          stateNext      = ST_STALL;
          strobe.advance = 1'b1;
        end
        ST_STALL:  if (stallAck) stateNext = ST_ACTIVE;
        default:   stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state <= ST_IDLE;
    else
      state <= stateNext;
  end

  assign stallValid = (state == ST_STALL);

  // R8: a failure while idle never raises a request
  assert_idle_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && opFail && !opStart) |=> !stallValid);

  // R10: a start wins over a simultaneous failure
  assert_start_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    opStart |=> (!stallValid && state == ST_ACTIVE));

  // R6: an unacknowledged request persists
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stallValid && !stallAck && !opStart && !opDone) |=> stallValid);

endmodule

// File: rtl/backoff_retry.sv
module backoff_retry
  import backoff_pkg::*;
#(
  parameter int CAP_LIMIT   = 4096,
  parameter int PAUSE_SHIFT = 7,
  localparam int CNT_W = $clog2(CAP_LIMIT) + 2,
  localparam int LEN_W = CNT_W + PAUSE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opStart,
  input  logic             opFail,
  input  logic             opDone,
  input  logic             stallAck,
  output logic             stallValid,
  output logic [LEN_W-1:0] stallLen
);

  boStrobe_t strobe;

  backoff_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .opStart    (opStart),
    .opFail     (opFail),
    .opDone     (opDone),
    .stallAck   (stallAck),
    .strobe     (strobe),
    .stallValid (stallValid)
  );

  backoff_datapath #(
    .CAP_LIMIT   (CAP_LIMIT),
    .PAUSE_SHIFT (PAUSE_SHIFT)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .stallLen (stallLen)
  );

  // R5: a raised request is a power of two with the low bits clear
  assert_len_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stallValid |-> ($onehot(stallLen) && stallLen[PAUSE_SHIFT-1:0] == '0));

  // R6: the length does not move while the request waits
  assert_len_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stallValid && !stallAck && !opStart && !opDone) |=> $stable(stallLen));

  // R6: the request drops after acknowledge
  assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stallValid && stallAck) |=> !stallValid);

endmodule

// File: tb/backoff_retry_tb.sv
module backoff_retry_tb_top;

  localparam int LEN_W = 21;
  localparam longint MAX_LEN = 64'd1048576;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             opStart = 1'b0;
  logic             opFail = 1'b0;
  logic             opDone = 1'b0;
  logic             stallAck = 1'b0;
  logic             stallValid;
  logic [LEN_W-1:0] stallLen;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state: 0 idle, 1 active, 2 stall
  int     mState = 0;
  longint mCnt   = 1;
  bit     mValid = 1'b0;
  longint mLen   = 0;

  always #4 clk = ~clk;

  backoff_retry dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .opStart    (opStart),
    .opFail     (opFail),
    .opDone     (opDone),
    .stallAck   (stallAck),
    .stallValid (stallValid),
    .stallLen   (stallLen)
  );

  task automatic modelStep(input bit s, input bit d, input bit f, input bit a);
    if (s) begin
      mCnt = 1; mState = 1; mValid = 1'b0;
    end else if (d) begin
      mState = 0; mValid = 1'b0;
    end else if (mState == 1 && f) begin
      mLen = mCnt * 128; mValid = 1'b1; mState = 2;
      if (mCnt <= 4096) mCnt = mCnt * 2;
    end else if (mState == 2 && a) begin
      mValid = 1'b0; mState = 1;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (stallValid !== mValid || (mValid && longint'(stallLen) != mLen)) begin
      errors++;
      $display("FAIL %s: valid=%0b len=%0d expected valid=%0b len=%0d",
               tag, stallValid, stallLen, mValid, mLen);
    end
  endtask

  task automatic step(input bit s, input bit d, input bit f, input bit a, input string tag);
    @(negedge clk);
    opStart = s; opDone = d; opFail = f; stallAck = a;
    @(posedge clk);
    modelStep(s, d, f, a);
    #1;
    compare(tag);
    opStart = 1'b0; opDone = 1'b0; opFail = 1'b0; stallAck = 1'b0;
  endtask

  task automatic expectVal(input bit expV, input longint expL, input string tag);
    checks++;
    if (stallValid !== expV || (expV && longint'(stallLen) != expL)) begin
      errors++;
      $display("FAIL %s: valid=%0b len=%0d expected valid=%0b len=%0d",
               tag, stallValid, stallLen, expV, expL);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectVal(1'b0, 0, "R1 valid during reset");
    rst_n = 1'b1;
    @(negedge clk);
    expectVal(1'b0, 0, "R1 valid after reset");

    // R8: failure while idle raises nothing
    step(0, 0, 1, 0, "R8 idle fail");
    step(0, 0, 0, 0, "R8 idle quiet");
    expectVal(1'b0, 0, "R8 idle fail ignored");

    // R2 first request
    step(1, 0, 0, 0, "R2 start");
    step(0, 0, 1, 0, "R2 first fail");
    expectVal(1'b1, 128, "R2 first stall 128");

    // R6/R7 hold and ignored failures
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "R7 fail while outstanding");
    expectVal(1'b1, 128, "R6 length held");
    step(0, 0, 0, 1, "R6 ack");
    expectVal(1'b0, 0, "R6 drop after ack");
    step(0, 0, 1, 0, "R7 next fail");
    expectVal(1'b1, 256, "R7 single doubling after ignored fails");
    step(0, 0, 0, 1, "R3 ack");

    // R3/R4 run to saturation: counts 4 .. 8192 then saturated
    for (int k = 2; k < 16; k++) begin
      step(0, 0, 1, 0, "R3 fail in run");
      step(0, 0, 0, 0, "R5 held");
      step(0, 0, 0, 1, "R3 ack in run");
    end
    step(0, 0, 1, 0, "R4 saturated fail");
    expectVal(1'b1, MAX_LEN, "R4 saturated length");
    step(0, 0, 0, 1, "R4 ack");
    step(0, 0, 1, 0, "R4 saturated again");
    expectVal(1'b1, MAX_LEN, "R4 stays saturated");

    // R8 success withdraws
    step(0, 1, 0, 0, "R8 done mid stall");
    expectVal(1'b0, 0, "R8 withdraw");
    step(0, 0, 1, 0, "R8 fail after done");
    expectVal(1'b0, 0, "R8 fail after done ignored");

    // R9 restart while outstanding
    step(1, 0, 0, 0, "R9 start");
    step(0, 0, 1, 0, "R9 fail");
    step(0, 0, 0, 1, "R9 ack");
    step(0, 0, 1, 0, "R9 fail 2");
    expectVal(1'b1, 256, "R9 second request");
    step(1, 0, 0, 0, "R9 restart outstanding");
    expectVal(1'b0, 0, "R9 withdraw on start");
    step(0, 0, 1, 0, "R9 fail after restart");
    expectVal(1'b1, 128, "R9 reload to 128");
    step(0, 0, 0, 1, "R9 ack");

    // R10 priority
    step(1, 0, 1, 0, "R10 start with fail");
    expectVal(1'b0, 0, "R10 start beats fail");
    step(0, 0, 1, 0, "R10 fail after start");
    expectVal(1'b1, 128, "R10 count reloaded");
    step(0, 0, 0, 1, "R10 ack");
    step(0, 1, 1, 0, "R10 done with fail");
    expectVal(1'b0, 0, "R10 done beats fail");
    step(0, 0, 1, 0, "R10 idle fail");
    expectVal(1'b0, 0, "R10 idle after done");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule